// File: doc/BRIEF.md
# Privilege Mode and Bank Remapper

This controller sits between a processor that issues 24-bit addresses and a physical memory of sixteen 64 KB banks. It tracks which protection mode the machine is in and decides, every bus cycle, which physical bank a logical bank maps to. Accesses that the processor sends to logical bank 0 are its direct-page, stack and vector accesses. In protected modes the controller can redirect them to the bank that belongs to the running process, so each process sees a private bank 0. In user mode, an access to any bank other than bank 0 or the process's own bank raises an abort request.

Four small control registers sit on a register port: the interrupted bank, the kernel bank, the user bank and a remap control register. Software can reach them only when the machine is not in user mode. A user-mode write is dropped and flagged as a violation. Writing the user bank performs a context switch into user mode. When an interrupt is taken, the bank in context is captured. The mode does not change until the processor signals a vector pull, so the pushed return frame still lands in the interrupted process's bank.

The four modes and their transitions are:
- REAL: the reset state, with no protection. An accepted user-bank write moves it to USER. A vector pull leaves it in REAL.
- USER: a vector pull moves it to INTR. Register writes are ignored here.
- KERNEL: a vector pull moves it to INTR. A user-bank write moves it to USER. A remap-control write keeps it in KERNEL.
- INTR: a remap-control write moves it to KERNEL. A user-bank write moves it to USER. A vector pull keeps it in INTR.

Top module: `bank_remap_ctl`

## Requirements
- R1: After reset, mode reads REAL (encoding 00), all four registers read 0 and the violation flag is 0.
- R2: In REAL mode, on a valid cycle, phys_bank equals log_bank[3:0] and abort_req is 0.
- R3: On an internal cycle (cyc_type 00), phys_bank is 0 and abort_req is 0 in every mode. The other cycle types (01 operand, 10 data, 11 opcode) are valid cycles.
- R4: In USER mode (encoding 01), a bank-0 access goes to the user bank when remap control bit 7 is set, and to physical bank 0 when bit 7 is clear. An access to log_bank equal to the user bank passes through with no abort.
- R5: In USER mode, a valid access to any other 8-bit logical bank asserts abort_req combinationally, and phys_bank is held at the user bank.
- R6: In KERNEL mode (encoding 10), when bit 7 is set, a bank-0 access goes to the kernel bank if remap control bit 6 is clear, and to remap control bits [3:0] if bit 6 is set. Other banks pass through, and abort_req is never asserted.
- R7: In any cycle with vec_pull high, phys_bank equals log_bank[3:0] with no abort. From USER or KERNEL the next mode is INTR (encoding 11). From REAL the mode stays REAL.
- R8: In INTR mode there is no remapping and no abort. An accepted write to the remap control register moves the machine to KERNEL.
- R9: A pulse on irq_take or nmi_take captures the bank in context into register 0 (user bank in USER; kernel bank in KERNEL or INTR; 0 in REAL) and leaves the mode unchanged.
- R10: The register map is 0 = interrupted bank, 1 = kernel bank, 2 = user bank, 3 = remap control. The bank registers read back zero-extended to 8 bits. The remap control register keeps bits 7, 6 and 3:0, and bits 5:4 read 0. The registers are writable in REAL, KERNEL and INTR.
- R11: The kernel bank register accepts only its first write after reset. Later writes leave it unchanged.
- R12: In USER mode, register writes change nothing, reg_rdata is 0, and priv_violation is high for exactly the one cycle after each attempted write.
- R13: An accepted write to the user bank register moves the machine to USER on the next cycle, and the new user bank is the remap target from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_type | input | 2 | Cycle type: 00 internal, 01 operand, 10 data, 11 opcode |
| log_bank | input | 8 | Logical bank issued by the processor |
| vec_pull | input | 1 | Vector-pull indication, active high |
| irq_take | input | 1 | Maskable interrupt accepted, one-cycle pulse |
| nmi_take | input | 1 | Non-maskable interrupt accepted, one-cycle pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Register write data |
| phys_bank | output | 4 | Physical bank |
| mode | output | 2 | Current mode: 00 REAL, 01 USER, 10 KERNEL, 11 INTR |
| reg_rdata | output | 8 | Register read data for reg_addr |
| abort_req | output | 1 | Protection fault, abort request |
| priv_violation | output | 1 | One-cycle flag after a user-mode register write |

## Verification
The bench targets a user-mode logical bank whose low nibble matches the user bank but whose high nibble does not. A remapper that compares only four bits would let that access through instead of aborting. It also checks the vector-pull cycle itself: a design that switched mode one cycle late, or that remapped the vector fetch, would send the vector read to the process bank instead of physical bank 0. The bench tries a second kernel-bank write, a user-mode write to the user bank, and a capture of the interrupted bank in both user and kernel mode. A wrong design would overwrite the kernel bank, switch context from user code, or record the wrong bank for the interrupt return.

// File: rtl/bank_remap_pkg.sv
package bank_remap_pkg;
    typedef enum logic [1:0] {
        MODE_REAL   = 2'b00,
        MODE_USER   = 2'b01,
        MODE_KERNEL = 2'b10,
        MODE_INTR   = 2'b11
    } mode_e;

    localparam logic [1:0] CYC_IDLE = 2'b00;

    localparam logic [1:0] RA_IBANK = 2'd0;
    localparam logic [1:0] RA_KBANK = 2'd1;
    localparam logic [1:0] RA_UBANK = 2'd2;
    localparam logic [1:0] RA_CTRL  = 2'd3;
endpackage

// File: rtl/bank_mode_fsm.sv
module bank_mode_fsm
    import bank_remap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vec_pull,
    input  logic  ubank_wr,
    input  logic  ctrl_wr,
    output mode_e state
);
    mode_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_REAL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_REAL: begin
                if (ubank_wr) state_nx = MODE_USER;
            end
            MODE_USER: begin
                if (vec_pull) state_nx = MODE_INTR;
            end
            MODE_KERNEL: begin
                if (vec_pull)      state_nx = MODE_INTR;
                else if (ubank_wr) state_nx = MODE_USER;
            end
            MODE_INTR: begin
                if (vec_pull)      state_nx = MODE_INTR;
                else if (ubank_wr) state_nx = MODE_USER;
                else if (ctrl_wr)  state_nx = MODE_KERNEL;
            end
            default: state_nx = MODE_REAL;
        endcase
    end

    AST_VPULL_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull && (state == MODE_USER || state == MODE_KERNEL) |=> state == MODE_INTR); // R7
    AST_REAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull && state == MODE_REAL |=> state == MODE_REAL); // R7
    AST_UBANK_TO_USER: assert property (@(posedge clk) disable iff (!rst_n)
        ubank_wr && !vec_pull |=> state == MODE_USER); // R13
endmodule

// File: rtl/bank_ctl_regs.sv
module bank_ctl_regs
    import bank_remap_pkg::*;
#(
    parameter int PBANK_W = 4,
    parameter int REG_W   = 8,
    parameter int EN_BIT  = 7,
    parameter int ALT_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              state,
    input  logic               irq_take,
    input  logic               nmi_take,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [PBANK_W-1:0] ubank,
    output logic [PBANK_W-1:0] kbank,
    output logic [REG_W-1:0]   ctrl,
    output logic [REG_W-1:0]   rdata,
    output logic               ubank_wr,
    output logic               ctrl_wr,
    output logic               violation
);
    localparam logic [REG_W-1:0] CTRL_MASK =
        REG_W'((1 << EN_BIT) | (1 << ALT_BIT) | ((1 << PBANK_W) - 1));
    localparam int PAD_W = REG_W - PBANK_W;

    logic [PBANK_W-1:0] ibank_q;
    logic               kset_q;
    logic               wr_ok;
    logic               capture;
    logic [PBANK_W-1:0] ctx_bank;

    assign wr_ok    = reg_wr && (state != MODE_USER);
    assign ubank_wr = wr_ok && (reg_addr == RA_UBANK);
    assign ctrl_wr  = wr_ok && (reg_addr == RA_CTRL);
    assign capture  = irq_take || nmi_take;

    always_comb begin
        unique case (state)
            MODE_USER:   ctx_bank = ubank;
            MODE_KERNEL: ctx_bank = kbank;
            MODE_INTR:   ctx_bank = kbank;
            default:     ctx_bank = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibank_q   <= '0;
            kbank     <= '0;
            kset_q    <= 1'b0;
            ubank     <= '0;
            ctrl      <= '0;
            violation <= 1'b0;
        end else begin
            violation <= reg_wr && (state == MODE_USER);
            if (capture)
                ibank_q <= ctx_bank;
            else if (wr_ok && reg_addr == RA_IBANK)
                ibank_q <= reg_wdata[PBANK_W-1:0];
            if (wr_ok && reg_addr == RA_KBANK && !kset_q) begin
                kbank  <= reg_wdata[PBANK_W-1:0];
                kset_q <= 1'b1;
            end
            if (ubank_wr) ubank <= reg_wdata[PBANK_W-1:0];
            if (ctrl_wr)  ctrl  <= reg_wdata & CTRL_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        if (state != MODE_USER) begin
            unique case (reg_addr)
                RA_IBANK: rdata = {{PAD_W{1'b0}}, ibank_q};
                RA_KBANK: rdata = {{PAD_W{1'b0}}, kbank};
                RA_UBANK: rdata = {{PAD_W{1'b0}}, ubank};
                RA_CTRL:  rdata = ctrl;
                default:  rdata = '0;
            endcase
        end
    end

    AST_USER_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && state == MODE_USER |=> violation); // R12
    AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && state == MODE_USER |=> $stable(ubank) && $stable(kbank) && $stable(ctrl)); // R12
    AST_KBANK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        kset_q |=> $stable(kbank)); // R11
    AST_USER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state == MODE_USER |-> rdata == '0); // R12
endmodule

// File: rtl/bank_remap_path.sv
module bank_remap_path
    import bank_remap_pkg::*;
#(
    parameter int LBANK_W = 8,
    parameter int PBANK_W = 4,
    parameter int REG_W   = 8,
    parameter int EN_BIT  = 7,
    parameter int ALT_BIT = 6
) (
    input  mode_e              state,
    input  logic [1:0]         cyc_type,
    input  logic [LBANK_W-1:0] log_bank,
    input  logic               vec_pull,
    input  logic [PBANK_W-1:0] ubank,
    input  logic [PBANK_W-1:0] kbank,
    input  logic [REG_W-1:0]   ctrl,
    output logic [PBANK_W-1:0] phys_bank,
    output logic               fault
);
    localparam int PAD_W = LBANK_W - PBANK_W;

    logic               valid;
    logic               zero_bank;
    logic               own_bank;
    logic               remap_en;
    logic [PBANK_W-1:0] kern_tgt;

    assign valid     = (cyc_type != CYC_IDLE);
    assign zero_bank = (log_bank == '0);
    assign own_bank  = (log_bank == {{PAD_W{1'b0}}, ubank});
    assign remap_en  = ctrl[EN_BIT];
    assign kern_tgt  = ctrl[ALT_BIT] ? ctrl[PBANK_W-1:0] : kbank;

    always_comb begin
        phys_bank = log_bank[PBANK_W-1:0];
        fault     = 1'b0;
        if (!valid) begin
            phys_bank = '0;
        end else if (!vec_pull) begin
            unique case (state)
                MODE_USER: begin
                    if (zero_bank) begin
                        phys_bank = remap_en ? ubank : '0;
                    end else if (!own_bank) begin
                        phys_bank = ubank;
                        fault     = 1'b1;
                    end
                end
                MODE_KERNEL: begin
                    if (zero_bank && remap_en) phys_bank = kern_tgt;
                end
                MODE_REAL: ;
                MODE_INTR: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bank_remap_ctl.sv
module bank_remap_ctl
    import bank_remap_pkg::*;
#(
    parameter int LBANK_W = 8,
    parameter int PBANK_W = 4,
    parameter int REG_W   = 8,
    parameter int EN_BIT  = 7,
    parameter int ALT_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cyc_type,
    input  logic [LBANK_W-1:0] log_bank,
    input  logic               vec_pull,
    input  logic               irq_take,
    input  logic               nmi_take,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [PBANK_W-1:0] phys_bank,
    output logic [1:0]         mode,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               abort_req,
    output logic               priv_violation
);
    mode_e              state;
    logic [PBANK_W-1:0] ubank;
    logic [PBANK_W-1:0] kbank;
    logic [REG_W-1:0]   ctrl;
    logic               ubank_wr;
    logic               ctrl_wr;

    bank_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vec_pull (vec_pull),
        .ubank_wr (ubank_wr),
        .ctrl_wr  (ctrl_wr),
        .state    (state)
    );

    bank_ctl_regs #(
        .PBANK_W (PBANK_W), .REG_W (REG_W), .EN_BIT (EN_BIT), .ALT_BIT (ALT_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .irq_take  (irq_take),
        .nmi_take  (nmi_take),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ubank     (ubank),
        .kbank     (kbank),
        .ctrl      (ctrl),
        .rdata     (reg_rdata),
        .ubank_wr  (ubank_wr),
        .ctrl_wr   (ctrl_wr),
        .violation (priv_violation)
    );

    bank_remap_path #(
        .LBANK_W (LBANK_W), .PBANK_W (PBANK_W), .REG_W (REG_W),
        .EN_BIT (EN_BIT), .ALT_BIT (ALT_BIT)
    ) u_path (
        .state     (state),
        .cyc_type  (cyc_type),
        .log_bank  (log_bank),
        .vec_pull  (vec_pull),
        .ubank     (ubank),
        .kbank     (kbank),
        .ctrl      (ctrl),
        .phys_bank (phys_bank),
        .fault     (abort_req)
    );

    assign mode = state;

    AST_PRIV_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        state != MODE_USER |-> !abort_req); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_type == CYC_IDLE |-> (phys_bank == '0 && !abort_req)); // R3
    AST_USER_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
        state == MODE_USER && cyc_type != CYC_IDLE && !vec_pull && log_bank != '0
        |-> phys_bank == ubank); // R5
    AST_VPULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull && cyc_type != CYC_IDLE |-> phys_bank == log_bank[PBANK_W-1:0] && !abort_req); // R7
endmodule

// File: tb/bank_remap_ctl_test.sv
module bank_remap_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cyc_type = 2'b00;
    logic [7:0] log_bank = 8'h00;
    logic       vec_pull = 1'b0;
    logic       irq_take = 1'b0;
    logic       nmi_take = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [3:0] phys_bank;
    logic [1:0] mode;
    logic [7:0] reg_rdata;
    logic       abort_req;
    logic       priv_violation;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bank_remap_ctl uut (
        .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .log_bank(log_bank),
        .vec_pull(vec_pull), .irq_take(irq_take), .nmi_take(nmi_take),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .phys_bank(phys_bank), .mode(mode), .reg_rdata(reg_rdata),
        .abort_req(abort_req), .priv_violation(priv_violation)
    );

    // {cyc[1:0], log_bank[7:0], exp_phys[3:0], exp_abort, unused}, user mode, user bank 6, remap on
    localparam logic [15:0] VEC [0:6] = '{
        {2'd3, 8'h00, 4'h6, 1'b0, 1'b0},
        {2'd1, 8'h00, 4'h6, 1'b0, 1'b0},
        {2'd2, 8'h06, 4'h6, 1'b0, 1'b0},
        {2'd2, 8'h07, 4'h6, 1'b1, 1'b0},
        {2'd2, 8'h16, 4'h6, 1'b1, 1'b0},
        {2'd3, 8'h0F, 4'h6, 1'b1, 1'b0},
        {2'd0, 8'h07, 4'h0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic acc_chk(input string req, input logic [1:0] c, input logic [7:0] lb,
                           input logic [3:0] ep, input logic ea);
        cyc_type = c; log_bank = lb;
        #1;
        chk({req, " phys"}, phys_bank, ep);
        chk({req, " abort"}, abort_req, ea);
        tick();
        cyc_type = 2'b00;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk("R1 mode", mode, 2'b00);
        chk("R1 violation", priv_violation, 1'b0);
        for (int i = 0; i < 4; i++) rd_chk("R1 reg", 2'(i), 8'h00);
        tick();

        // R2 real mode pass-through, R3 idle cycle
        acc_chk("R2 real", 2'd2, 8'h35, 4'h5, 1'b0);
        acc_chk("R3 idle", 2'd0, 8'h35, 4'h0, 1'b0);
        // R7 vector pull in real mode stays real
        vec_pull = 1'b1;
        acc_chk("R7 real vpull", 2'd3, 8'h00, 4'h0, 1'b0);
        vec_pull = 1'b0;
        #1 chk("R7 real stays", mode, 2'b00);
        tick();

        // R9 capture in real mode gives 0
        irq_take = 1'b1; tick(); irq_take = 1'b0;
        rd_chk("R9 real capture", 2'd0, 8'h00);

        // R10/R11 kernel bank write once
        wr(2'd1, 8'h0A);
        rd_chk("R10 kbank", 2'd1, 8'h0A);
        wr(2'd1, 8'h03);
        rd_chk("R11 kbank once", 2'd1, 8'h0A);
        wr(2'd3, 8'hFF);
        rd_chk("R10 ctrl mask", 2'd3, 8'hCF);
        wr(2'd3, 8'h80);

        // R13 user bank write enters user mode
        wr(2'd2, 8'h06);
        #1 chk("R13 to user", mode, 2'b01);
        tick();

        // R4/R5 table walk in user mode
        for (int i = 0; i < 7; i++) begin
            acc_chk("R4/R5 table", VEC[i][15:14], VEC[i][13:6], VEC[i][5:2], VEC[i][1]);
        end

        // R12 user register access
        rd_chk("R12 user read", 2'd1, 8'h00);
        wr(2'd2, 8'h09);
        #1 chk("R12 violation", priv_violation, 1'b1);
        chk("R12 mode", mode, 2'b01);
        tick();
        #1 chk("R12 violation pulse", priv_violation, 1'b0);
        tick();
        acc_chk("R12 ubank kept", 2'd2, 8'h00, 4'h6, 1'b0);

        // R9 capture in user mode, mode unchanged
        irq_take = 1'b1; tick(); irq_take = 1'b0;
        #1 chk("R9 mode kept", mode, 2'b01);
        tick();
        // R7 vector pull cycle goes to physical bank 0, then INTR
        vec_pull = 1'b1;
        acc_chk("R7 vpull", 2'd3, 8'h00, 4'h0, 1'b0);
        vec_pull = 1'b0;
        #1 chk("R7 to intr", mode, 2'b11);
        tick();
        rd_chk("R9 ibank user", 2'd0, 8'h06);

        // R8 interrupt mode, no remap
        acc_chk("R8 intr bank0", 2'd2, 8'h00, 4'h0, 1'b0);
        acc_chk("R8 intr other", 2'd2, 8'h25, 4'h5, 1'b0);
        wr(2'd3, 8'hC3);
        #1 chk("R8 to kernel", mode, 2'b10);
        tick();

        // R6 kernel mode targets
        acc_chk("R6 alt target", 2'd2, 8'h00, 4'h3, 1'b0);
        wr(2'd3, 8'h80);
        #1 chk("R6 stays kernel", mode, 2'b10);
        tick();
        acc_chk("R6 kbank target", 2'd1, 8'h00, 4'hA, 1'b0);
        acc_chk("R6 other bank", 2'd2, 8'h07, 4'h7, 1'b0);
        nmi_take = 1'b1; tick(); nmi_take = 1'b0;
        rd_chk("R9 ibank kernel", 2'd0, 8'h0A);
        wr(2'd3, 8'h00);
        acc_chk("R6 remap off", 2'd2, 8'h00, 4'h0, 1'b0);

        // R4 remap off in user mode; R13 new user bank
        wr(2'd2, 8'h06);
        acc_chk("R4 user remap off", 2'd2, 8'h00, 4'h0, 1'b0);
        acc_chk("R4 own bank", 2'd3, 8'h06, 4'h6, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule